// File: doc/BRIEF.md
# BCH Error Count Classifier

This block looks at the three syndrome parts of a received word from a shortened binary BCH code that corrects two errors and detects three. From them it reports how many bits went wrong: none, one, two or three. The parts are a 1-bit overall parity syndrome, plus two 7-bit syndromes S1 and S3 over GF(2^7) with field polynomial x^7+x^3+1. The code is (79,64) with 15 check bits. Correction logic further down the read path uses the flag to choose a cheap single-error path or a full double-error path for each word. It can also skip correction entirely when the word is clean or cannot be corrected.

The block forms sigma0 = S1^3 + S3 in combinational field logic. The cube is a squarer followed by a multiplier, both plain XOR/AND networks. A single wide OR of sigma0 tells a lone error apart from a triple error when the parity is odd. With even parity, any nonzero syndrome bit means two errors. A parameter selects whether the flag is registered. The default is registered.

Top module: `err_count_cls`

## Requirements
- R1: `flag_o` uses this encoding: 2'b00 for no error, 2'b01 for one error, 2'b10 for two errors and 2'b11 for three errors, which cannot be corrected.
- R2: Bit 0 of the flag equals the parity syndrome `par_i`, so odd error counts give odd flag codes.
- R3: With `par_i`=0 and every bit of `syn1_i` and `syn3_i` zero, the flag is 2'b00.
- R4: With `par_i`=0 and any bit of `syn1_i` or `syn3_i` set, the flag is 2'b10. This includes `syn1_i`=0 with `syn3_i` nonzero.
- R5: With `par_i`=1 and `syn3_i` equal to `syn1_i` cubed in GF(2^7) mod x^7+x^3+1, the flag is 2'b01. This includes both syndromes zero, which is an error in the parity bit itself.
- R6: With `par_i`=1 and `syn3_i` different from `syn1_i` cubed, the flag is 2'b11.
- R7: With the default `REG_OUT`=1, the flag shows the inputs sampled at a rising clock edge. It keeps its old value until that edge.
- R8: While `rst_ni` is low the flag is 2'b00, and it clears at once when reset asserts.
- R9: Take any set of 1, 2 or 3 distinct error positions i in 0..78, with S1 = XOR of alpha^i, S3 = XOR of alpha^(3i) and parity = count mod 2. For every such set, the flag equals the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_i | input | 1 | Overall parity syndrome |
| syn1_i | input | 7 | Syndrome S1 in GF(2^7) |
| syn3_i | input | 7 | Syndrome S3 in GF(2^7) |
| flag_o | output | 2 | Error count code |

## Verification
The hardest case to reach from real error patterns is odd parity with S3 different from S1 cubed while S1 itself is zero. The hardest even case is S1 zero with S3 nonzero. Neither comes up by chance, because three errors seldom sum to zero in S1. The bench therefore computes syndromes of random 1-, 2- and 3-bit patterns with its own field arithmetic. It also drives directed syndrome triples for these edge cases, and random S1 values paired with their exact cube or with a perturbed cube.

// File: rtl/err_cls_pkg.sv
package err_cls_pkg;
  localparam int unsigned GF_M    = 7;
  localparam logic [6:0]  GF_TAPS = 7'h09;  // x^3 + 1 below the x^7 term

  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_ONE   = 2'b01,
    ERR_TWO   = 2'b10,
    ERR_THREE = 2'b11
  } err_cnt_e;
endpackage

// File: rtl/gf_reduce.sv
module gf_reduce #(
  parameter int unsigned M    = 7,
  parameter logic [M-1:0] TAPS = 7'h09,
  localparam int unsigned W   = 2*M-1
) (
  input  logic [W-1:0] wide_i,
  output logic [M-1:0] red_o
);
  logic [M-1:0] acc;
  logic         msb;

  // Horner evaluation: acc = acc*x + wide[k] mod p(x)
  always_comb begin
    acc = '0;
    msb = 1'b0;
    for (int k = W-1; k >= 0; k--) begin
      msb = acc[M-1];
      acc = {acc[M-2:0], wide_i[k]} ^ (msb ? TAPS : '0);
    end
  end

  assign red_o = acc;
endmodule

// File: rtl/gf_sqr.sv
module gf_sqr #(
  parameter int unsigned M    = 7,
  parameter logic [M-1:0] TAPS = 7'h09
) (
  input  logic [M-1:0] a_i,
  output logic [M-1:0] sq_o
);
  localparam int unsigned W = 2*M-1;
  logic [W-1:0] spread;

  always_comb begin
    spread = '0;
    for (int i = 0; i < M; i++) spread[2*i] = a_i[i];
  end

  gf_reduce #(.M(M), .TAPS(TAPS)) u_red (.wide_i(spread), .red_o(sq_o));
endmodule

// File: rtl/gf_mul.sv
module gf_mul #(
  parameter int unsigned M    = 7,
  parameter logic [M-1:0] TAPS = 7'h09
) (
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic [M-1:0] p_o
);
  localparam int unsigned W = 2*M-1;
  logic [W-1:0] prod;

  always_comb begin
    prod = '0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        prod[i+j] = prod[i+j] ^ (a_i[i] & b_i[j]);
  end

  gf_reduce #(.M(M), .TAPS(TAPS)) u_red (.wide_i(prod), .red_o(p_o));
endmodule

// File: rtl/gf_cube.sv
module gf_cube #(
  parameter int unsigned M    = 7,
  parameter logic [M-1:0] TAPS = 7'h09
) (
  input  logic [M-1:0] a_i,
  output logic [M-1:0] cube_o
);
  logic [M-1:0] a_sq;

  gf_sqr #(.M(M), .TAPS(TAPS)) u_sqr (.a_i(a_i), .sq_o(a_sq));
  gf_mul #(.M(M), .TAPS(TAPS)) u_mul (.a_i(a_sq), .b_i(a_i), .p_o(cube_o));
endmodule

// File: rtl/err_cls_enc.sv
module err_cls_enc
  import err_cls_pkg::*;
(
  input  logic     par_i,
  input  logic     any_syn_i,
  input  logic     sig_nz_i,
  output err_cnt_e flag_o
);
  always_comb begin
    if (!par_i) flag_o = any_syn_i ? ERR_TWO   : ERR_NONE;
    else        flag_o = sig_nz_i  ? ERR_THREE : ERR_ONE;
  end
endmodule

// File: rtl/err_count_cls.sv
module err_count_cls
  import err_cls_pkg::*;
#(
  parameter int unsigned M       = GF_M,
  parameter logic [M-1:0] TAPS    = GF_TAPS,
  parameter bit           REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         par_i,
  input  logic [M-1:0] syn1_i,
  input  logic [M-1:0] syn3_i,
  output logic [1:0]   flag_o
);
  logic [M-1:0] s1_cube;
  logic [M-1:0] sigma0;
  logic         any_syn;
  logic         sig_nz;
  err_cnt_e     flag_d;

  gf_cube #(.M(M), .TAPS(TAPS)) u_cube (.a_i(syn1_i), .cube_o(s1_cube));

  assign sigma0  = s1_cube ^ syn3_i;
  assign sig_nz  = |sigma0;
  assign any_syn = |{syn1_i, syn3_i};

  err_cls_enc u_enc (
    .par_i    (par_i),
    .any_syn_i(any_syn),
    .sig_nz_i (sig_nz),
    .flag_o   (flag_d)
  );

  if (REG_OUT) begin : g_reg
    logic [1:0] flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= ERR_NONE;
      else         flag_q <= flag_d;
    end
    assign flag_o = flag_q;

    assert_odd_parity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      par_i |=> flag_o[0]);
    assert_even_parity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !par_i |=> !flag_o[0]);
    assert_clean_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!par_i && syn1_i == '0 && syn3_i == '0) |=> flag_o == ERR_NONE);
    assert_even_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!par_i && (syn1_i != '0 || syn3_i != '0)) |=> flag_o == ERR_TWO);
    assert_parity_bit_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (par_i && syn1_i == '0 && syn3_i == '0) |=> flag_o == ERR_ONE);
    assert_odd_s3_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (par_i && syn1_i == '0 && syn3_i != '0) |=> flag_o == ERR_THREE);
  end else begin : g_comb
    assign flag_o = flag_d;
  end
endmodule

// File: tb/err_count_cls_bench.sv
module err_count_cls_bench;
  localparam int M = 7;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         par_i = 1'b0;
  logic [M-1:0] syn1_i = '0;
  logic [M-1:0] syn3_i = '0;
  logic [1:0]   flag_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct { int cyc; logic [1:0] exp; string req; } item_t;
  item_t sb_q[$];

  err_count_cls u_err_count_cls (
    .clk_i(clk_i), .rst_ni(rst_ni), .par_i(par_i),
    .syn1_i(syn1_i), .syn3_i(syn3_i), .flag_o(flag_o)
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  function automatic logic [M-1:0] xtime(logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [M-1:0] gmul(logic [M-1:0] a, logic [M-1:0] b);
    logic [M-1:0] r = '0;
    for (int i = M-1; i >= 0; i--) begin
      r = xtime(r);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] apow(int e);
    logic [M-1:0] r = 7'h01;
    for (int i = 0; i < e; i++) r = xtime(r);
    return r;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic drive(logic p, logic [M-1:0] s1, logic [M-1:0] s3,
                       logic [1:0] exp, string req);
    item_t it;
    @(negedge clk_i);
    par_i = p; syn1_i = s1; syn3_i = s3;
    it.cyc = cyc; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor: result is visible one edge after drive (R7 latency)
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      while (sb_q.size() > 0 && sb_q[0].cyc < cyc) begin
        check(sb_q[0].req, flag_o, sb_q[0].exp);
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic inject(int n);
    int pos[3];
    logic [M-1:0] s1 = '0, s3 = '0;
    for (int k = 0; k < n; k++) begin
      bit dup;
      do begin
        pos[k] = $urandom_range(0, 78);
        dup = 1'b0;
        for (int j = 0; j < k; j++) if (pos[j] == pos[k]) dup = 1'b1;
      end while (dup);
      s1 ^= apow(pos[k]);
      s3 ^= apow((3*pos[k]) % 127);
    end
    drive(n[0], s1, s3, n[1:0], "R9");
  endtask

  initial begin
    #2;
    check("R8 reset", flag_o, 2'b00);
    #20 rst_ni = 1'b1;

    drive(1'b0, '0, '0, 2'b00, "R3");
    drive(1'b0, '0, 7'h15, 2'b10, "R4 s1 zero");
    drive(1'b0, 7'h40, '0, 2'b10, "R4 s3 zero");
    drive(1'b1, '0, '0, 2'b01, "R5 parity only");
    drive(1'b1, '0, 7'h01, 2'b11, "R6 s3 only");
    drive(1'b1, 7'h01, 7'h01, 2'b01, "R5 alpha0");
    drive(1'b1, 7'h7f, 7'h00, 2'b11, "R6 R2");

    for (int i = 0; i < 60; i++) begin
      logic [M-1:0] a = M'($urandom_range(1, 127));
      logic [M-1:0] c = gmul(gmul(a, a), a);
      drive(1'b1, a, c, 2'b01, "R5 cube");
      drive(1'b1, a, c ^ M'($urandom_range(1, 127)), 2'b11, "R6 cube");
    end

    for (int i = 0; i < 400; i++) inject(i % 4);
    drain();

    drive(1'b0, '0, '0, 2'b00, "R1");
    drive(1'b0, '0, '0, 2'b00, "R1");
    drain();
    @(negedge clk_i);
    par_i = 1'b1; syn1_i = '0; syn3_i = 7'h22;
    #3;
    check("R7 hold", flag_o, 2'b00);
    @(negedge clk_i);
    check("R7 update", flag_o, 2'b11);

    rst_ni = 1'b0;
    #1;
    check("R8 async", flag_o, 2'b00);
    @(negedge clk_i);
    check("R8 held", flag_o, 2'b00);
    rst_ni = 1'b1;
    drive(1'b0, 7'h03, 7'h05, 2'b10, "R4 R1 after reset");
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule